// File: doc/BRIEF.md
# DMA Descriptor Control Word Store with Retirement Race Resolution

This block holds the control/status half of every DMA channel's descriptor, together with each channel's 32-bit last-address / scatter-gather address word. Software reaches both through a simple register write and read port. The transfer engine reports two events per channel: it has begun executing the channel, or it has retired the channel at the end of its major loop.

On retirement the block samples the channel's chaining enable and scatter-gather enable. It then issues a one-cycle link request carrying the stored link channel number, or a one-cycle fetch request carrying the stored scatter-gather address, or both.

Software may set the two enables while a channel runs. This opens a race against retirement. The block settles the race with one rule: a control-word write that lands while the done flag is set, or in the same cycle as retirement of that channel, stores both enables as zero. Software reads the word back to learn whether its late enable was accepted. Because the link channel field is ignored while chaining is off, it can carry a descriptor tag. It is read in the same access as the scatter-gather enable.

Top module: `dmadesc_csr`

## Requirements
- R1: While `rst` is high and on the first cycle after, every control word and address word is zero, and `rd_data`, `hw_act`, `link_start`, `link_ch`, `sg_fetch` and `sg_addr` are zero.
- R2: The control word is 16 bits, returned zero-extended on `rd_data` the cycle after a read with `rd_sel`=0. Layout: bit0 start, bit1 done, bit2 chain enable, bit3 scatter-gather enable, bit4 hardware-disable, bits 11:8 link channel. All other bits read zero. `rd_data` is zero in cycles without a read, and a read returns the value before any same-cycle write.
- R3: A control-word write (`wr_sel`=0) to a channel whose done bit is set stores the written start, done, hardware-disable and link channel fields, but stores chain enable and scatter-gather enable as zero.
- R4: A control-word write to a channel whose done bit is clear stores chain enable and scatter-gather enable as written, so they can be set while the channel runs.
- R5: `start_ev` clears the done and start bits of `start_ch`. This overrides a same-cycle write to that channel, unless the channel also retires in that cycle.
- R6: `retire_ev` sets the done bit of `retire_ch`. If that channel's chain enable was 1 before the edge, `link_start` pulses for one cycle on the next cycle, with `link_ch` equal to the stored link channel. Otherwise both stay zero.
- R7: If the retiring channel's scatter-gather enable was 1 before the edge, `sg_fetch` pulses on the next cycle with `sg_addr` equal to its stored address word. Otherwise both are zero.
- R8: When a control-word write and retirement hit the same channel in the same cycle, retirement samples the enables from before the write. The done bit ends at 1, and the written enables are stored as zero.
- R9: `reload_ev` replaces the whole control word of `reload_ch` with `reload_word`, including the new enables, and its address word with `reload_addr`. This takes priority over any same-cycle write to that control word. While `reload_ev` is high, every software address-word write is dropped.
- R10: `hw_act[c]` equals, one cycle later, `hw_req[c]` masked by the inverse of channel c's hardware-disable bit.
- R11: With chain enable 0, retirement produces no `link_start`, whatever value the link channel field holds.
- R12: An address-word write (`wr_sel`=1) stores all 32 bits. A read with `rd_sel`=1 returns them one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 1 | 0 = control word, 1 = address word |
| wr_ch | input | CH_W | Channel written |
| wr_data | input | AW | Write data (control word uses bits 15:0) |
| rd_en | input | 1 | Software read strobe |
| rd_sel | input | 1 | 0 = control word, 1 = address word |
| rd_ch | input | CH_W | Channel read |
| rd_data | output | AW | Registered read data |
| start_ev | input | 1 | Engine begins executing a channel |
| start_ch | input | CH_W | Channel starting |
| retire_ev | input | 1 | Engine retires a channel |
| retire_ch | input | CH_W | Channel retiring |
| reload_ev | input | 1 | Fetched descriptor ready to install |
| reload_ch | input | CH_W | Channel being reloaded |
| reload_word | input | 16 | New control word |
| reload_addr | input | AW | New address word |
| hw_req | input | NUM_CH | Raw hardware service requests |
| hw_act | output | NUM_CH | Requests passed to the engine |
| link_start | output | 1 | Chained-start pulse |
| link_ch | output | 4 | Channel to start by chaining |
| sg_fetch | output | 1 | Scatter-gather fetch pulse |
| sg_addr | output | AW | Address of the next descriptor |

## Verification
The assertions check the race rules on every cycle. A write landing on a done channel, or on a channel retiring in that cycle, must leave both enables clear. Retirement must leave done set, and a start must leave it clear. A pulse on either request output must follow a retirement, and no disabled channel's request may pass. The bench's directed scenarios and its reference model cover the rest. That covers the exact link number and fetch address sampled before a colliding write, the fields that survive a masked write, the reload replacing the enables, and the dropped address write during a reload.

// File: rtl/dma_cs_pkg.sv
package dma_cs_pkg;
  localparam int CSW     = 16;
  localparam int LCH_W   = 4;
  localparam int B_START = 0;
  localparam int B_DONE  = 1;
  localparam int B_CHAIN = 2;
  localparam int B_SG    = 3;
  localparam int B_HWDIS = 4;
  localparam int B_LCH   = 8;

  typedef struct packed {
    logic [LCH_W-1:0] lch;
    logic             hwdis;
    logic             sg;
    logic             chain;
    logic             done;
    logic             start;
  } cs_t;

  function automatic logic [CSW-1:0] cs_pack(input cs_t c);
    logic [CSW-1:0] w;
    w = '0;
    w[B_START] = c.start;
    w[B_DONE]  = c.done;
    w[B_CHAIN] = c.chain;
    w[B_SG]    = c.sg;
    w[B_HWDIS] = c.hwdis;
    w[B_LCH +: LCH_W] = c.lch;
    return w;
  endfunction

  function automatic cs_t cs_unpack(input logic [CSW-1:0] w);
    cs_t c;
    c.start = w[B_START];
    c.done  = w[B_DONE];
    c.chain = w[B_CHAIN];
    c.sg    = w[B_SG];
    c.hwdis = w[B_HWDIS];
    c.lch   = w[B_LCH +: LCH_W];
    return c;
  endfunction
endpackage

// File: rtl/dma_cs_chan.sv
module dma_cs_chan
  import dma_cs_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_hit,
  input  logic [CSW-1:0] wr_word,
  input  logic           start_hit,
  input  logic           retire_hit,
  input  logic           rl_hit,
  input  logic [CSW-1:0] rl_word,
  output cs_t            cs_q
);
  cs_t nxt;
  logic lock;

  always_comb begin
    nxt  = cs_q;
    // the enables are refused once done is set or retirement is in progress
    lock = cs_q.done | retire_hit;
    if (wr_hit) begin
      nxt = cs_unpack(wr_word);
      if (lock) begin
        nxt.chain = 1'b0;
        nxt.sg    = 1'b0;
      end
    end
    if (retire_hit) begin
      nxt.done = 1'b1;
    end else if (start_hit) begin
      nxt.done  = 1'b0;
      nxt.start = 1'b0;
    end
    if (rl_hit) nxt = cs_unpack(rl_word);
  end

  always_ff @(posedge clk) begin
    if (rst) cs_q <= '0;
    else     cs_q <= nxt;
  end
endmodule

// File: rtl/dma_cs_sga.sv
module dma_cs_sga #(
  parameter int NUM_CH = 4,
  parameter int AW     = 32,
  parameter int CH_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [CH_W-1:0] wa,
  input  logic [AW-1:0]   wd,
  input  logic            ra_en,
  input  logic [CH_W-1:0] ra,
  output logic [AW-1:0]   rq,
  input  logic            fa_en,
  input  logic [CH_W-1:0] fa,
  output logic [AW-1:0]   fq
);
  logic [AW-1:0] mem [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rq <= '0;
      fq <= '0;
    end else begin
      rq <= ra_en ? mem[ra] : '0;
      fq <= fa_en ? mem[fa] : '0;
    end
  end
endmodule

// File: rtl/dma_cs_retire.sv
module dma_cs_retire
  import dma_cs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             retire_ev,
  input  cs_t              ret_cs,
  output logic             link_start,
  output logic [LCH_W-1:0] link_ch,
  output logic             sg_fetch
);
  always_ff @(posedge clk) begin
    if (rst) begin
      link_start <= 1'b0;
      link_ch    <= '0;
      sg_fetch   <= 1'b0;
    end else begin
      link_start <= retire_ev & ret_cs.chain;
      link_ch    <= (retire_ev & ret_cs.chain) ? ret_cs.lch : '0;
      sg_fetch   <= retire_ev & ret_cs.sg;
    end
  end
endmodule

// File: rtl/dmadesc_csr.sv
module dmadesc_csr
  import dma_cs_pkg::*;
#(
  parameter  int NUM_CH = 4,
  parameter  int AW     = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [AW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [AW-1:0]     rd_data,
  input  logic              start_ev,
  input  logic [CH_W-1:0]   start_ch,
  input  logic              retire_ev,
  input  logic [CH_W-1:0]   retire_ch,
  input  logic              reload_ev,
  input  logic [CH_W-1:0]   reload_ch,
  input  logic [CSW-1:0]    reload_word,
  input  logic [AW-1:0]     reload_addr,
  input  logic [NUM_CH-1:0] hw_req,
  output logic [NUM_CH-1:0] hw_act,
  output logic              link_start,
  output logic [LCH_W-1:0]  link_ch,
  output logic              sg_fetch,
  output logic [AW-1:0]     sg_addr
);
  cs_t               cs [NUM_CH];
  logic [NUM_CH-1:0] done_vec, chain_vec, sg_vec, hwdis_vec;
  logic [CSW-1:0]    rd_cs_q;
  logic [AW-1:0]     sga_rq, sga_fq;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dma_cs_chan u_chan (
      .clk        (clk),
      .rst        (rst),
      .wr_hit     (wr_en && !wr_sel && (wr_ch == CH_W'(g))),
      .wr_word    (wr_data[CSW-1:0]),
      .start_hit  (start_ev && (start_ch == CH_W'(g))),
      .retire_hit (retire_ev && (retire_ch == CH_W'(g))),
      .rl_hit     (reload_ev && (reload_ch == CH_W'(g))),
      .rl_word    (reload_word),
      .cs_q       (cs[g])
    );
    assign done_vec[g]  = cs[g].done;
    assign chain_vec[g] = cs[g].chain;
    assign sg_vec[g]    = cs[g].sg;
    assign hwdis_vec[g] = cs[g].hwdis;

    always_ff @(posedge clk) begin
      if (rst) hw_act[g] <= 1'b0;
      else     hw_act[g] <= hw_req[g] & ~cs[g].hwdis;
    end
  end

  // single write port: a fetched descriptor wins over software
  dma_cs_sga #(.NUM_CH(NUM_CH), .AW(AW), .CH_W(CH_W)) u_sga (
    .clk   (clk),
    .rst   (rst),
    .we    (reload_ev | (wr_en & wr_sel)),
    .wa    (reload_ev ? reload_ch : wr_ch),
    .wd    (reload_ev ? reload_addr : wr_data),
    .ra_en (rd_en & rd_sel),
    .ra    (rd_ch),
    .rq    (sga_rq),
    .fa_en (retire_ev & cs[retire_ch].sg),
    .fa    (retire_ch),
    .fq    (sga_fq)
  );

  dma_cs_retire u_ret (
    .clk        (clk),
    .rst        (rst),
    .retire_ev  (retire_ev),
    .ret_cs     (cs[retire_ch]),
    .link_start (link_start),
    .link_ch    (link_ch),
    .sg_fetch   (sg_fetch)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_cs_q <= '0;
    else     rd_cs_q <= (rd_en && !rd_sel) ? cs_pack(cs[rd_ch]) : '0;
  end

  assign rd_data = {{(AW-CSW){1'b0}}, rd_cs_q} | sga_rq;
  assign sg_addr = sga_fq;
endmodule

// File: rtl/dmadesc_csr_chk.sv
module dmadesc_csr_chk #(
  parameter int NUM_CH = 4,
  parameter int AW     = 32,
  parameter int CH_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [CH_W-1:0]   wr_ch,
  input logic              start_ev,
  input logic [CH_W-1:0]   start_ch,
  input logic              retire_ev,
  input logic [CH_W-1:0]   retire_ch,
  input logic              reload_ev,
  input logic [CH_W-1:0]   reload_ch,
  input logic [NUM_CH-1:0] hw_act,
  input logic              link_start,
  input logic              sg_fetch,
  input logic [AW-1:0]     rd_data,
  input logic [NUM_CH-1:0] done_vec,
  input logic [NUM_CH-1:0] chain_vec,
  input logic [NUM_CH-1:0] sg_vec,
  input logic [NUM_CH-1:0] hwdis_vec
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!link_start && !sg_fetch && rd_data == '0 && hw_act == '0)); // R1

  AST_LATE_ENABLE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel && done_vec[wr_ch] && !(reload_ev && reload_ch == wr_ch))
    |=> (!chain_vec[$past(wr_ch)] && !sg_vec[$past(wr_ch)])); // R3

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    (start_ev && !(retire_ev && retire_ch == start_ch) && !(reload_ev && reload_ch == start_ch))
    |=> !done_vec[$past(start_ch)]); // R5

  AST_RETIRE_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
    (retire_ev && !(reload_ev && reload_ch == retire_ch))
    |=> done_vec[$past(retire_ch)]); // R6

  AST_LINK_AFTER_RETIRE: assert property (@(posedge clk) disable iff (rst)
    link_start |-> $past(retire_ev)); // R6

  AST_FETCH_AFTER_RETIRE: assert property (@(posedge clk) disable iff (rst)
    sg_fetch |-> $past(retire_ev)); // R7

  AST_COLLIDE_MASKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel && retire_ev && retire_ch == wr_ch && !(reload_ev && reload_ch == wr_ch))
    |=> (done_vec[$past(wr_ch)] && !chain_vec[$past(wr_ch)] && !sg_vec[$past(wr_ch)])); // R8

  AST_DISABLED_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (hw_act & $past(hwdis_vec)) == '0); // R10
endmodule

bind dmadesc_csr dmadesc_csr_chk #(.NUM_CH(NUM_CH), .AW(AW), .CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_ch      (wr_ch),
  .start_ev   (start_ev),
  .start_ch   (start_ch),
  .retire_ev  (retire_ev),
  .retire_ch  (retire_ch),
  .reload_ev  (reload_ev),
  .reload_ch  (reload_ch),
  .hw_act     (hw_act),
  .link_start (link_start),
  .sg_fetch   (sg_fetch),
  .rd_data    (rd_data),
  .done_vec   (done_vec),
  .chain_vec  (chain_vec),
  .sg_vec     (sg_vec),
  .hwdis_vec  (hwdis_vec)
);

// File: tb/sim_dmadesc_csr.sv
`timescale 1ns/1ps
module sim_dmadesc_csr;
  localparam int NCH = 4;
  localparam int AW  = 32;
  localparam int CW  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, wr_sel = 0, rd_en = 0, rd_sel = 0;
  logic start_ev = 0, retire_ev = 0, reload_ev = 0;
  logic [CW-1:0] wr_ch = 0, rd_ch = 0, start_ch = 0, retire_ch = 0, reload_ch = 0;
  logic [AW-1:0] wr_data = 0, reload_addr = 0;
  logic [15:0]   reload_word = 0;
  logic [NCH-1:0] hw_req = 0;
  logic [AW-1:0]  rd_data, sg_addr;
  logic [NCH-1:0] hw_act;
  logic           link_start, sg_fetch;
  logic [3:0]     link_ch;

  always #4 clk = ~clk;

  dmadesc_csr #(.NUM_CH(NCH), .AW(AW)) u0 (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_ch(rd_ch), .rd_data(rd_data),
    .start_ev(start_ev), .start_ch(start_ch),
    .retire_ev(retire_ev), .retire_ch(retire_ch),
    .reload_ev(reload_ev), .reload_ch(reload_ch),
    .reload_word(reload_word), .reload_addr(reload_addr),
    .hw_req(hw_req), .hw_act(hw_act),
    .link_start(link_start), .link_ch(link_ch),
    .sg_fetch(sg_fetch), .sg_addr(sg_addr)
  );

  // behavioural reference state
  logic [15:0]    m_cs  [NCH];
  logic [AW-1:0]  m_sga [NCH];
  logic [AW-1:0]  e_rd = 0, e_sa = 0;
  logic           e_ls = 0, e_sf = 0;
  logic [3:0]     e_lch = 0;
  logic [NCH-1:0] e_act = 0;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    logic [15:0] nx [NCH];
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin m_cs[c] = 0; m_sga[c] = 0; end
      e_rd = 0; e_sa = 0; e_ls = 0; e_sf = 0; e_lch = 0; e_act = 0;
    end else begin
      e_rd  = !rd_en ? '0 : (rd_sel ? m_sga[rd_ch] : {16'h0, m_cs[rd_ch]});
      e_ls  = retire_ev && m_cs[retire_ch][2];
      e_lch = e_ls ? m_cs[retire_ch][11:8] : 4'h0;
      e_sf  = retire_ev && m_cs[retire_ch][3];
      e_sa  = e_sf ? m_sga[retire_ch] : '0;
      for (int c = 0; c < NCH; c++) begin
        e_act[c] = hw_req[c] && !m_cs[c][4];
        nx[c] = m_cs[c];
        if (wr_en && !wr_sel && wr_ch == c) begin
          nx[c] = wr_data[15:0] & 16'h0F1F;
          if (m_cs[c][1] || (retire_ev && retire_ch == c)) nx[c][3:2] = 2'b00;
        end
        if (retire_ev && retire_ch == c) nx[c][1] = 1'b1;
        else if (start_ev && start_ch == c) nx[c][1:0] = 2'b00;
        if (reload_ev && reload_ch == c) nx[c] = reload_word & 16'h0F1F;
      end
      if (reload_ev) m_sga[reload_ch] = reload_addr;
      else if (wr_en && wr_sel) m_sga[wr_ch] = wr_data;
      for (int c = 0; c < NCH; c++) m_cs[c] = nx[c];
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (rd_data !== e_rd || link_start !== e_ls || link_ch !== e_lch ||
        sg_fetch !== e_sf || sg_addr !== e_sa || hw_act !== e_act) begin
      errors++;
      $display("FAIL %s t=%0t rd=%h/%h ls=%b/%b lch=%h/%h sf=%b/%b sa=%h/%h act=%b/%b",
               cur_req, $time, rd_data, e_rd, link_start, e_ls, link_ch, e_lch,
               sg_fetch, e_sf, sg_addr, e_sa, hw_act, e_act);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    wr_en = 0; rd_en = 0; start_ev = 0; retire_ev = 0; reload_ev = 0;
  endtask

  task automatic wcs(input int ch, input logic [15:0] v);
    wr_en = 1; wr_sel = 0; wr_ch = CW'(ch); wr_data = {16'h0, v}; step();
  endtask

  task automatic wsga(input int ch, input logic [31:0] v);
    wr_en = 1; wr_sel = 1; wr_ch = CW'(ch); wr_data = v; step();
  endtask

  task automatic rd(input int ch, input logic s);
    rd_en = 1; rd_sel = s; rd_ch = CW'(ch); step(); step();
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    rd(0, 0); rd(3, 1);

    cur_req = "R2";
    wcs(1, 16'h0515); rd(1, 0);
    wcs(2, 16'hFFFF); rd(2, 0);

    cur_req = "R3";  // ch2 done=1 so enables refused
    wcs(2, 16'h030C); rd(2, 0);
    cur_req = "R4";
    wcs(2, 16'h030C); rd(2, 0);

    cur_req = "R12";
    wsga(2, 32'hDEADBEEF); rd(2, 1);

    cur_req = "R5";
    wcs(3, 16'h0003); start_ev = 1; start_ch = 2'd3; step(); rd(3, 0);

    cur_req = "R6";  // ch2: chain+sg, link 3
    retire_ev = 1; retire_ch = 2'd2; step(); step(); rd(2, 0);
    cur_req = "R7";
    wsga(1, 32'h0000_1000); wcs(1, 16'h0508);
    retire_ev = 1; retire_ch = 2'd1; step(); step();

    cur_req = "R11";
    wcs(0, 16'h0700); retire_ev = 1; retire_ch = 2'd0; step(); step();

    cur_req = "R8";
    wcs(0, 16'h0000);
    wr_en = 1; wr_sel = 0; wr_ch = 2'd0; wr_data = 32'h000C;
    retire_ev = 1; retire_ch = 2'd0; step(); step(); rd(0, 0);
    wcs(3, 16'h0604);
    wr_en = 1; wr_sel = 0; wr_ch = 2'd3; wr_data = 32'h0000;
    retire_ev = 1; retire_ch = 2'd3; step(); step(); rd(3, 0);

    cur_req = "R9";
    wr_en = 1; wr_sel = 1; wr_ch = 2'd1; wr_data = 32'h5555_AAAA;
    reload_ev = 1; reload_ch = 2'd2; reload_word = 16'h090C; reload_addr = 32'h1234_5678;
    step(); rd(2, 0); rd(2, 1); rd(1, 1);

    cur_req = "R10";
    wcs(3, 16'h0010); hw_req = 4'hF; step(); step(); hw_req = 4'h0; step();

    cur_req = "R8";  // random mix of all events
    for (int i = 0; i < 3000; i++) begin
      wr_en = $urandom_range(0, 1); wr_sel = $urandom_range(0, 1);
      wr_ch = CW'($urandom); wr_data = $urandom;
      rd_en = $urandom_range(0, 1); rd_sel = $urandom_range(0, 1); rd_ch = CW'($urandom);
      start_ev = ($urandom_range(0, 3) == 0); start_ch = CW'($urandom);
      retire_ev = ($urandom_range(0, 3) == 0); retire_ch = CW'($urandom);
      reload_ev = ($urandom_range(0, 7) == 0); reload_ch = CW'($urandom);
      reload_word = 16'($urandom); reload_addr = $urandom;
      hw_req = NCH'($urandom);
      @(negedge clk);
    end
    step(); step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule